// File: doc/BRIEF.md
# Tree Partial-Sum Reduction Engine

The engine keeps one accumulator per lane. While idle, every lane adds the elements presented on its own input slot, so each accumulator builds the partial sum of that lane's contiguous slice of a larger data set. A start pulse freezes the inputs, latches how many lanes take part, and runs a halving reduction that folds all active partial sums into lane 0. Each round of the reduction takes one clock cycle. The next-round values of every lane are computed from the register contents left by the previous round, so the register boundary acts as the synchronisation barrier between rounds.

Two halving schemes are selectable per job. In shared mode a lane count that is odd is handled by folding the topmost active lane into lane 0 before halving with truncation. In message mode the half is rounded upward and a moving limit marks which lanes still hold live values. Both schemes give the same wrapping two's-complement total. They differ in how many rounds they take. When the reduction ends, the total appears on the result output together with a one-cycle done pulse, and all accumulators return to zero for the next job.

The controller is a four-state machine. ST_IDLE accumulates elements and waits for start. ST_SHARED runs one shared-mode round per cycle. ST_MSG runs one message-mode round per cycle. ST_DONE captures the result and clears the lanes. The transitions are as follows:
- IDLE to SHARED on start with mode 0 and more than one lane.
- IDLE to MSG on start with mode 1 and more than one lane.
- IDLE to DONE on start with one lane.
- SHARED or MSG to DONE when the next half equals 1.
- DONE to IDLE unconditionally.

Top module: `psum_reduce_engine`

## Requirements
- R1: After reset, busy_o and done_o are 0, sum_o is 0 and every lane accumulator holds 0.
- R2: While idle, lane i adds the element at elem_data_i bits [i*DW +: DW] on every clock where elem_valid_i bit i is 1. The addition wraps modulo 2^DW. An element presented in the same cycle as an accepted start is still added.
- R3: A start pulse while idle latches the lane count N from lane_cnt_i. A value of 0 counts as 1, and a value above LANES counts as LANES. Accumulators at index N or above do not contribute to the result.
- R4: In shared mode (mode_i = 0), half starts at N. In each round: if half is odd, lane 0 also adds lane half-1; half then becomes floor(half/2); each lane below the new half adds lane index+half. Rounds stop once half equals 1.
- R5: In message mode (mode_i = 1), half and limit start at N. In each round half becomes ceil(half/2), each lane below floor(limit/2) adds lane index+half, and limit then takes the new half. Rounds stop once half equals 1.
- R6: All lane updates of one round use only the values held before that round, and exactly one round is done per clock.
- R7: busy_o is 1 from the cycle after an accepted start for R+1 cycles, where R is the number of rounds of the chosen mode. done_o is then high for exactly one cycle, in the same cycle that busy_o falls. sum_o shows the total from that cycle and holds it until the next done pulse.
- R8: With N equal to 1 no round is run: busy_o is 1 for one cycle and done_o follows with lane 0's sum.
- R9: While busy, start pulses and element inputs are ignored. They neither restart the job nor reach any later total.
- R10: When done_o is high every accumulator has been cleared to 0. The next job sums only elements accepted after that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for the reduction |
| mode_i | input | 1 | Scheme select: 0 shared halving, 1 message halving |
| lane_cnt_i | input | $clog2(LANES+1) | Number of active lanes N |
| elem_valid_i | input | LANES | Per-lane element valid flags |
| elem_data_i | input | LANES*DW | Per-lane elements, lane i at bits [i*DW +: DW] |
| sum_o | output | DW | Final reduced sum |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Reduction in progress |

## Verification
A wrong half or limit value shows at the ports in one of two ways. The done pulse may arrive a cycle early or late, because the count of rounds follows the halving sequence directly. A lane may also be dropped or counted twice, which gives a wrong sum_o in the done cycle. The reference model predicts the number of rounds for each mode and lane count. It also predicts the sequential total of every accepted element, so a wrong round count is caught in the first cycle busy_o or done_o differs, and a wrong total is caught at the done pulse of that job. A faulty clear or a leak from inputs while busy stays hidden until the done pulse of the following job.

// File: rtl/rdx_pkg.sv
package rdx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHARED = 2'd1,
        ST_MSG    = 2'd2,
        ST_DONE   = 2'd3
    } rdx_state_e;
endpackage

// File: rtl/rdx_round_net.sv
module rdx_round_net #(
    parameter int LANES = 8,
    parameter int DW    = 16,
    parameter int CW    = 4
) (
    input  logic                        msg_mode,
    input  logic [CW-1:0]               half,
    input  logic [CW-1:0]               limit,
    input  logic [LANES-1:0][DW-1:0]    cur,
    output logic [LANES-1:0][DW-1:0]    nxt,
    output logic [CW-1:0]               nxt_half
);
    localparam int IW = (LANES > 1) ? $clog2(LANES) : 1;

    always_comb begin
        int h;
        int hn;
        int rcv;
        nxt = cur;
        h   = int'(half);
        if (msg_mode) begin
            hn  = (h + 1) / 2;
            rcv = int'(limit) / 2;
        end else begin
            hn  = h / 2;
            rcv = hn;
        end
        for (int i = 0; i < LANES; i++) begin
            if (i < rcv && (i + hn) < LANES)
                nxt[i] = cur[i] + cur[IW'(i + hn)];
        end
        // odd fold of the top active lane into lane 0 (shared scheme)
        if (!msg_mode && (h % 2) == 1 && h > 1 && (h - 1) < LANES)
            nxt[0] = nxt[0] + cur[IW'(h - 1)];
        nxt_half = CW'(hn);
    end
endmodule

// File: rtl/rdx_lane_bank.sv
module rdx_lane_bank #(
    parameter int LANES = 8,
    parameter int DW    = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        upd,
    input  logic                        acc,
    input  logic [LANES-1:0]            din_vld,
    input  logic [LANES-1:0][DW-1:0]    din,
    input  logic [LANES-1:0][DW-1:0]    nxt,
    output logic [LANES-1:0][DW-1:0]    lanes
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                lanes[g] <= '0;
            else if (upd)
                lanes[g] <= nxt[g];
            else if (acc && din_vld[g])
                lanes[g] <= lanes[g] + din[g];
        end
    end
endmodule

// File: rtl/psum_reduce_engine.sv
module psum_reduce_engine
    import rdx_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DW    = 16,
    localparam int CW   = $clog2(LANES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  mode_i,
    input  logic [CW-1:0]         lane_cnt_i,
    input  logic [LANES-1:0]      elem_valid_i,
    input  logic [LANES*DW-1:0]   elem_data_i,
    output logic [DW-1:0]         sum_o,
    output logic                  done_o,
    output logic                  busy_o
);
    rdx_state_e                   state_q, state_d;
    logic [CW-1:0]                half_q, limit_q, nxt_half, eff_n;
    logic [LANES-1:0][DW-1:0]     lanes, nxt_lanes, din;
    logic                         in_round;

    assign din      = elem_data_i;
    assign in_round = (state_q == ST_SHARED) || (state_q == ST_MSG);
    assign busy_o   = (state_q != ST_IDLE);

    always_comb begin
        if (lane_cnt_i == '0)
            eff_n = CW'(1);
        else if (lane_cnt_i > CW'(LANES))
            eff_n = CW'(LANES);
        else
            eff_n = lane_cnt_i;
    end

    rdx_round_net #(.LANES(LANES), .DW(DW), .CW(CW)) u_net (
        .msg_mode (state_q == ST_MSG),
        .half     (half_q),
        .limit    (limit_q),
        .cur      (lanes),
        .nxt      (nxt_lanes),
        .nxt_half (nxt_half)
    );

    rdx_lane_bank #(.LANES(LANES), .DW(DW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_q == ST_DONE),
        .upd     (in_round),
        .acc     (state_q == ST_IDLE),
        .din_vld (elem_valid_i),
        .din     (din),
        .nxt     (nxt_lanes),
        .lanes   (lanes)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (eff_n == CW'(1))
                        state_d = ST_DONE;
                    else if (mode_i)
                        state_d = ST_MSG;
                    else
                        state_d = ST_SHARED;
                end
            end
            ST_SHARED, ST_MSG: begin
                if (nxt_half == CW'(1))
                    state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            half_q  <= CW'(1);
            limit_q <= CW'(1);
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                half_q  <= eff_n;
                limit_q <= eff_n;
            end else if (in_round) begin
                half_q  <= nxt_half;
                limit_q <= nxt_half;
            end
        end
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            sum_o  <= '0;
        end else begin
            done_o <= (state_q == ST_DONE);
            if (state_q == ST_DONE)
                sum_o <= lanes[0];
        end
    end

    AST_HALF_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        in_round |=> (half_q < $past(half_q)));                          // R4
    AST_FINISH_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> (half_q == CW'(1)));                   // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                            // R7
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);                                            // R7
    AST_SUM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(sum_o));                                    // R7
    AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && lane_cnt_i == CW'(1)) |=> (state_q == ST_DONE)); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && state_q != ST_DONE) |=> busy_o);          // R9
    AST_CLEARED_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lanes == '0));                                      // R10
endmodule

// File: tb/tb_psum_reduce_engine.sv
module tb_psum_reduce_engine;
    localparam int LANES = 8;
    localparam int DW    = 16;
    localparam int CW    = $clog2(LANES + 1);
    localparam longint MASK = (64'd1 << DW) - 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start_i = 1'b0;
    logic                 mode_i = 1'b0;
    logic [CW-1:0]        lane_cnt_i = '0;
    logic [LANES-1:0]     elem_valid_i = '0;
    logic [LANES*DW-1:0]  elem_data_i = '0;
    logic [DW-1:0]        sum_o;
    logic                 done_o;
    logic                 busy_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit cmp_en   = 1'b0;
    string tag   = "R1";

    longint acc [LANES];
    bit     m_busy;
    int     m_cnt;
    bit     m_done;
    longint m_sum;
    longint m_total;

    always #4 clk = ~clk;

    psum_reduce_engine #(.LANES(LANES), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .lane_cnt_i(lane_cnt_i), .elem_valid_i(elem_valid_i),
        .elem_data_i(elem_data_i), .sum_o(sum_o), .done_o(done_o), .busy_o(busy_o)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int rounds_for(int n, bit msg);
        int h = n;
        int r = 0;
        while (h != 1) begin
            h = msg ? (h + 1) / 2 : h / 2;
            r++;
        end
        return r;
    endfunction

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LANES; i++) acc[i] = 0;
            m_busy = 0; m_cnt = 0; m_done = 0; m_sum = 0; m_total = 0;
        end else begin
            m_done = 0;
            if (!m_busy) begin
                for (int i = 0; i < LANES; i++)
                    if (elem_valid_i[i])
                        acc[i] = (acc[i] + longint'(elem_data_i[i*DW +: DW])) & MASK;
                if (start_i) begin
                    int n;
                    n = int'(lane_cnt_i);
                    if (n == 0) n = 1;
                    if (n > LANES) n = LANES;
                    m_total = 0;
                    for (int i = 0; i < n; i++) m_total = (m_total + acc[i]) & MASK;
                    m_cnt  = rounds_for(n, mode_i) + 1;
                    m_busy = 1;
                end
            end else begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 0;
                    m_done = 1;
                    m_sum  = m_total;
                    for (int i = 0; i < LANES; i++) acc[i] = 0;
                end
            end
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R7", "busy_o", longint'(busy_o), longint'(m_busy));
            chk(m_done ? tag : "R7", "done_o", longint'(done_o), longint'(m_done));
            chk(tag, "sum_o", longint'(sum_o), m_sum);
        end
    end

    task automatic drive_random();
        elem_valid_i = LANES'($urandom);
        for (int i = 0; i < LANES; i++)
            elem_data_i[i*DW +: DW] = DW'($urandom);
    endtask

    task automatic feed(int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            drive_random();
        end
    endtask

    // one job: feed, start, poke ignored inputs while busy, then drain
    task automatic run_job(int n, bit msg, string t);
        tag = t;
        feed(5);
        @(negedge clk);
        drive_random();
        start_i    = 1'b1;
        mode_i     = msg;
        lane_cnt_i = CW'(n);
        @(negedge clk);
        drive_random();
        start_i    = 1'b1;          // R9: start while busy
        mode_i     = ~msg;
        lane_cnt_i = CW'(1);
        @(negedge clk);
        start_i    = 1'b0;
        elem_valid_i = '1;          // R9: elements while busy or done
        for (int c = 0; c < 6; c++) @(negedge clk);
        elem_valid_i = '0;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy_o after reset", longint'(busy_o), 0);
        chk("R1", "done_o after reset", longint'(done_o), 0);
        chk("R1", "sum_o after reset", longint'(sum_o), 0);
        cmp_en = 1'b1;

        for (int n = 1; n <= LANES; n++) begin
            run_job(n, 1'b0, (n == 1) ? "R8" : ((n % 2) == 1 ? "R6" : "R4"));
            run_job(n, 1'b1, (n == 1) ? "R8" : "R5");
        end

        // R2: wrapping accumulation with large elements
        tag = "R2";
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            elem_valid_i = '1;
            for (int i = 0; i < LANES; i++)
                elem_data_i[i*DW +: DW] = DW'(16'hFFF0 - i);
        end
        @(negedge clk);
        elem_valid_i = '0;
        start_i = 1'b1; mode_i = 1'b0; lane_cnt_i = CW'(LANES);
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c < 6; c++) @(negedge clk);

        // R3: lane count clamping
        run_job(0, 1'b0, "R3");
        run_job(12, 1'b1, "R3");
        run_job(15, 1'b0, "R3");

        // R10: back-to-back jobs without extra feeding between them
        run_job(LANES, 1'b1, "R10");
        tag = "R10";
        @(negedge clk);
        start_i = 1'b1; mode_i = 1'b0; lane_cnt_i = CW'(5);
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c < 6; c++) @(negedge clk);

        // R9: burst of starts during a long message job
        run_job(7, 1'b1, "R9");

        cmp_en = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule